// File: doc/BRIEF.md
# Neural Layer Sequencer with Alternating Activation Halves

This block runs a chain of neural-network layers on a near-memory accelerator after a single start command. For each output of a layer it computes a weight row address and sends it to every weight bank at once. It then waits out the fixed read latency of the weight memory before it lets the multiply-accumulate cluster start. When the row it needs is the same row it fetched last, it skips the read and the wait, because weights do not change during inference.

Input vectors come from the input buffer for the first layer and from one half of a two-half activation buffer for every later layer. Results go into the other half. The block swaps the two halves at each layer boundary, so one layer's outputs become the next layer's inputs without any copy. Each layer is described by a base weight address, an input length and an output count. The block reads these descriptor fields from a lookup that the surrounding logic indexes with the current layer number.

Top module: `lseq_top`

## Requirements
- R1: On `start_i` while idle, `busy_o` is high from the next cycle and the block runs layers 0 to `last_layer_i` in order. A `start_i` seen while busy has no effect on the run.
- R2: For output index o of a layer, the weight address is base+o (modulo 2^ADDR_W). It appears on every bank's address slice, and all bank read enables pulse together for one cycle.
- R3: After a bank read enable, `wgt_vld_o` rises exactly FETCH_LAT cycles later, and `mac_en_o` stays low until then.
- R4: When the address equals the last address that was read, no bank read is issued, and `wgt_vld_o` rises within 3 cycles of the previous write-back, or of the cycle in which the start was accepted.
- R5: Reset clears the remembered address, so the first fetch after reset always issues a bank read, even for address 0.
- R6: For each output, compute lasts exactly input-length cycles, reading buffer addresses 0,1,… in order, with `wgt_vld_o` on the first of them. One `quant_o` cycle follows, then one write cycle at address o. Reads and writes never coincide.
- R7: Layer 0 reads with `buf_rd_src_o`=0 (input buffer) and writes with `buf_wr_half_o`=0 (half A).
- R8: Layer k>0 reads from the half layer k-1 wrote (src 1 = half A, 2 = half B) and writes the other half (0 = A, 1 = B).
- R9: A layer with input length or output count equal to 0 or greater than HALF_DEPTH is not started. `err_o` rises, `busy_o` drops, and no write and no done follow. `err_o` stays set until the next accepted start.
- R10: `done_o` is high for exactly the one cycle after the final write-back of the last layer.
- R11: While reset is held, `busy_o`, `done_o`, `err_o`, all bank enables and both buffer enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a layer chain |
| last_layer_i | input | LAYER_W | Index of the final layer, sampled at start |
| busy_o | output | 1 | Chain in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Descriptor rejected |
| layer_o | output | LAYER_W | Current layer index for descriptor lookup |
| desc_base_i | input | ADDR_W | Base weight address of current layer |
| desc_in_len_i | input | LEN_W | Input vectors per output |
| desc_out_cnt_i | input | LEN_W | Outputs of the layer |
| bank_addr_o | output | NUM_BANKS*ADDR_W | Weight address, one slice per bank |
| bank_rd_en_o | output | NUM_BANKS | Weight read launch per bank |
| wgt_vld_o | output | 1 | Weights valid, first compute cycle |
| mac_en_o | output | 1 | Compute cycle |
| quant_o | output | 1 | Quantization cycle |
| buf_rd_en_o | output | 1 | Buffer read enable |
| buf_rd_src_o | output | 2 | Read source: 0 input, 1 half A, 2 half B |
| buf_rd_addr_o | output | IDX_W | Buffer read address |
| buf_wr_en_o | output | 1 | Activation write enable |
| buf_wr_half_o | output | 1 | Write half: 0 A, 1 B |
| buf_wr_addr_o | output | IDX_W | Activation write address |

## Verification
The bench builds the block with FETCH_LAT=6, HALF_DEPTH=8, MAX_LAYERS=4 and ADDR_W=8. With the short latency, the exact fetch wait can be counted over many outputs in a short run. With half depth 8, both the accepted boundary (length and count of 8) and the rejected length of 9 are reached with small vectors. Four layer slots are enough to see the halves alternate A, B, A. An 8-bit address gives chosen base values that line up so that the last row of one layer repeats as the first row of the next, and so that a new run repeats the previous run's final row.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
  typedef enum logic [1:0] {
    SRC_INBUF = 2'd0,
    SRC_PP_A  = 2'd1,
    SRC_PP_B  = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_FETCH, ST_WAIT, ST_COMP, ST_QUANT, ST_WB, ST_DONE
  } state_e;
endpackage

// File: rtl/lseq_fetch.sv
module lseq_fetch #(
  parameter int ADDR_W    = 12,
  parameter int FETCH_LAT = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              issue_o,
  output logic              ready_o
);
  localparam int CNT_W = (FETCH_LAT > 2) ? $clog2(FETCH_LAT) : 1;

  logic [ADDR_W-1:0] last_q;
  logic              last_vld_q;
  logic              wait_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              hit;

  assign hit     = last_vld_q && (last_q == addr_i);
  assign issue_o = req_i && !hit;
  assign ready_o = (req_i && hit) || (wait_q && (cnt_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q     <= '0;
      last_vld_q <= 1'b0;
      wait_q     <= 1'b0;
      cnt_q      <= '0;
    end else if (issue_o) begin
      last_q     <= addr_i;
      last_vld_q <= 1'b1;
      wait_q     <= 1'b1;
      cnt_q      <= CNT_W'(FETCH_LAT - 2);
    end else if (wait_q) begin
      if (cnt_q == '0) wait_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/lseq_pingpong.sv
module lseq_pingpong
  import lseq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic first_i,
  input  logic adv_i,
  output src_e src_o,
  output logic dst_o
);
  logic first_q;
  logic dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      dst_q   <= 1'b0;
    end else if (first_i) begin
      first_q <= 1'b1;
      dst_q   <= 1'b0;
    end else if (adv_i) begin
      first_q <= 1'b0;
      dst_q   <= ~dst_q;
    end
  end

  // source is whichever half the previous layer filled
  always_comb begin
    if (first_q)    src_o = SRC_INBUF;
    else if (dst_q) src_o = SRC_PP_A;
    else            src_o = SRC_PP_B;
  end
  assign dst_o = dst_q;
endmodule

// File: rtl/lseq_bank_fanout.sv
module lseq_bank_fanout #(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        en_i,
  output logic [NUM_BANKS*ADDR_W-1:0] bank_addr_o,
  output logic [NUM_BANKS-1:0]        bank_en_o
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign bank_addr_o[g*ADDR_W +: ADDR_W] = addr_i;
    assign bank_en_o[g]                    = en_i;
  end
endmodule

// File: rtl/lseq_ctrl.sv
module lseq_ctrl
  import lseq_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int HALF_DEPTH = 64,
  parameter int MAX_LAYERS = 16,
  localparam int LEN_W     = $clog2(HALF_DEPTH + 1),
  localparam int IDX_W     = $clog2(HALF_DEPTH),
  localparam int LAYER_W   = $clog2(MAX_LAYERS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LAYER_W-1:0] last_layer_i,
  input  logic [ADDR_W-1:0]  desc_base_i,
  input  logic [LEN_W-1:0]   desc_in_len_i,
  input  logic [LEN_W-1:0]   desc_out_cnt_i,
  input  logic               fetch_ready_i,
  output logic               fetch_req_o,
  output logic [ADDR_W-1:0]  fetch_addr_o,
  output logic               pp_first_o,
  output logic               pp_adv_o,
  output logic [LAYER_W-1:0] layer_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic               wgt_vld_o,
  output logic               mac_en_o,
  output logic               quant_o,
  output logic               rd_en_o,
  output logic [IDX_W-1:0]   rd_addr_o,
  output logic               wr_en_o,
  output logic [IDX_W-1:0]   wr_addr_o
);
  state_e             st_q, st_d;
  logic [LAYER_W-1:0] layer_q, last_layer_q;
  logic [ADDR_W-1:0]  base_q;
  logic [LEN_W-1:0]   len_q, cnt_q;
  logic [IDX_W-1:0]   in_q, out_q;
  logic               err_q;
  logic               desc_bad, last_in, last_out, last_layer;

  assign desc_bad = (desc_in_len_i == '0) || (desc_in_len_i > LEN_W'(HALF_DEPTH)) ||
                    (desc_out_cnt_i == '0) || (desc_out_cnt_i > LEN_W'(HALF_DEPTH));
  assign last_in    = in_q  == IDX_W'(len_q - 1'b1);
  assign last_out   = out_q == IDX_W'(cnt_q - 1'b1);
  assign last_layer = layer_q == last_layer_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_LOAD;
      ST_LOAD:  st_d = desc_bad ? ST_IDLE : ST_FETCH;
      ST_FETCH: st_d = fetch_ready_i ? ST_COMP : ST_WAIT;
      ST_WAIT:  if (fetch_ready_i) st_d = ST_COMP;
      ST_COMP:  if (last_in) st_d = ST_QUANT;
      ST_QUANT: st_d = ST_WB;
      ST_WB: begin
        if (!last_out)       st_d = ST_FETCH;
        else if (last_layer) st_d = ST_DONE;
        else                 st_d = ST_LOAD;
      end
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      layer_q      <= '0;
      last_layer_q <= '0;
      base_q       <= '0;
      len_q        <= '0;
      cnt_q        <= '0;
      in_q         <= '0;
      out_q        <= '0;
      err_q        <= 1'b0;
    end else begin
      st_q <= st_d;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          layer_q      <= '0;
          last_layer_q <= last_layer_i;
          err_q        <= 1'b0;
        end
        ST_LOAD: begin
          if (desc_bad) err_q <= 1'b1;
          base_q <= desc_base_i;
          len_q  <= desc_in_len_i;
          cnt_q  <= desc_out_cnt_i;
          out_q  <= '0;
        end
        ST_FETCH: in_q <= '0;
        ST_COMP:  if (!last_in) in_q <= in_q + 1'b1;
        ST_WB: begin
          if (!last_out)        out_q   <= out_q + 1'b1;
          else if (!last_layer) layer_q <= layer_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign fetch_req_o  = st_q == ST_FETCH;
  assign fetch_addr_o = base_q + ADDR_W'(out_q);
  assign pp_first_o   = (st_q == ST_IDLE) && start_i;
  assign pp_adv_o     = (st_q == ST_WB) && last_out && !last_layer;
  assign layer_o      = layer_q;
  assign busy_o       = st_q != ST_IDLE;
  assign done_o       = st_q == ST_DONE;
  assign err_o        = err_q;
  assign mac_en_o     = st_q == ST_COMP;
  assign wgt_vld_o    = (st_q == ST_COMP) && (in_q == '0);
  assign quant_o      = st_q == ST_QUANT;
  assign rd_en_o      = st_q == ST_COMP;
  assign rd_addr_o    = in_q;
  assign wr_en_o      = st_q == ST_WB;
  assign wr_addr_o    = out_q;
endmodule

// File: rtl/lseq_top.sv
module lseq_top
  import lseq_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int ADDR_W     = 12,
  parameter int FETCH_LAT  = 30,
  parameter int HALF_DEPTH = 64,
  parameter int MAX_LAYERS = 16,
  localparam int LEN_W     = $clog2(HALF_DEPTH + 1),
  localparam int IDX_W     = $clog2(HALF_DEPTH),
  localparam int LAYER_W   = $clog2(MAX_LAYERS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [LAYER_W-1:0]          last_layer_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        err_o,
  output logic [LAYER_W-1:0]          layer_o,
  input  logic [ADDR_W-1:0]           desc_base_i,
  input  logic [LEN_W-1:0]            desc_in_len_i,
  input  logic [LEN_W-1:0]            desc_out_cnt_i,
  output logic [NUM_BANKS*ADDR_W-1:0] bank_addr_o,
  output logic [NUM_BANKS-1:0]        bank_rd_en_o,
  output logic                        wgt_vld_o,
  output logic                        mac_en_o,
  output logic                        quant_o,
  output logic                        buf_rd_en_o,
  output logic [1:0]                  buf_rd_src_o,
  output logic [IDX_W-1:0]            buf_rd_addr_o,
  output logic                        buf_wr_en_o,
  output logic                        buf_wr_half_o,
  output logic [IDX_W-1:0]            buf_wr_addr_o
);
  logic              fetch_req, fetch_issue, fetch_ready;
  logic [ADDR_W-1:0] fetch_addr;
  logic              pp_first, pp_adv;
  src_e              pp_src;

  lseq_ctrl #(
    .ADDR_W(ADDR_W), .HALF_DEPTH(HALF_DEPTH), .MAX_LAYERS(MAX_LAYERS)
  ) i_ctrl (
    .clk_i, .rst_ni, .start_i, .last_layer_i,
    .desc_base_i, .desc_in_len_i, .desc_out_cnt_i,
    .fetch_ready_i (fetch_ready),
    .fetch_req_o   (fetch_req),
    .fetch_addr_o  (fetch_addr),
    .pp_first_o    (pp_first),
    .pp_adv_o      (pp_adv),
    .layer_o, .busy_o, .done_o, .err_o,
    .wgt_vld_o, .mac_en_o, .quant_o,
    .rd_en_o   (buf_rd_en_o),
    .rd_addr_o (buf_rd_addr_o),
    .wr_en_o   (buf_wr_en_o),
    .wr_addr_o (buf_wr_addr_o)
  );

  lseq_fetch #(.ADDR_W(ADDR_W), .FETCH_LAT(FETCH_LAT)) i_fetch (
    .clk_i, .rst_ni,
    .req_i   (fetch_req),
    .addr_i  (fetch_addr),
    .issue_o (fetch_issue),
    .ready_o (fetch_ready)
  );

  lseq_pingpong i_pp (
    .clk_i, .rst_ni,
    .first_i (pp_first),
    .adv_i   (pp_adv),
    .src_o   (pp_src),
    .dst_o   (buf_wr_half_o)
  );

  lseq_bank_fanout #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) i_fanout (
    .addr_i      (fetch_addr),
    .en_i        (fetch_issue),
    .bank_addr_o (bank_addr_o),
    .bank_en_o   (bank_rd_en_o)
  );

  assign buf_rd_src_o = pp_src;
endmodule

// File: rtl/lseq_sva.sv
module lseq_sva #(
  parameter int NUM_BANKS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 err_o,
  input logic [NUM_BANKS-1:0] bank_rd_en_o,
  input logic                 wgt_vld_o,
  input logic                 mac_en_o,
  input logic                 quant_o,
  input logic                 buf_rd_en_o,
  input logic [1:0]           buf_rd_src_o,
  input logic                 buf_wr_en_o,
  input logic                 buf_wr_half_o
);
  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_no_mac_after_issue_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bank_rd_en_o) |=> !mac_en_o);

  assert_vld_in_mac_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wgt_vld_o |-> mac_en_o);

  assert_quant_then_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quant_o |=> buf_wr_en_o);

  assert_rd_wr_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(buf_rd_en_o && buf_wr_en_o));

  assert_write_other_half_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_en_o |-> ($past(buf_rd_src_o, 2) != (buf_wr_half_o ? 2'd2 : 2'd1)));

  assert_err_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);
endmodule

bind lseq_top lseq_sva #(.NUM_BANKS(NUM_BANKS)) i_sva (
  .clk_i, .rst_ni, .busy_o, .done_o, .err_o, .bank_rd_en_o,
  .wgt_vld_o, .mac_en_o, .quant_o, .buf_rd_en_o, .buf_rd_src_o,
  .buf_wr_en_o, .buf_wr_half_o
);

// File: tb/test_lseq_top.sv
`timescale 1ns/1ps
module test_lseq_top;
  localparam int NB = 8, AW = 8, LAT = 6, HD = 8, ML = 4;
  localparam int LW = $clog2(HD + 1), IW = $clog2(HD), YW = $clog2(ML);

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [YW-1:0] last_layer_i = '0, layer_o;
  logic busy_o, done_o, err_o, wgt_vld_o, mac_en_o, quant_o;
  logic buf_rd_en_o, buf_wr_en_o, buf_wr_half_o;
  logic [1:0] buf_rd_src_o;
  logic [IW-1:0] buf_rd_addr_o, buf_wr_addr_o;
  logic [NB*AW-1:0] bank_addr_o;
  logic [NB-1:0] bank_rd_en_o;
  logic [AW-1:0] desc_base_i;
  logic [LW-1:0] desc_in_len_i, desc_out_cnt_i;

  int d_base [ML];
  int d_len [ML];
  int d_cnt [ML];
  int checks = 0, failures = 0;
  bit m_vld = 0;
  int m_last = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign desc_base_i    = AW'(d_base[layer_o]);
  assign desc_in_len_i  = LW'(d_len[layer_o]);
  assign desc_out_cnt_i = LW'(d_cnt[layer_o]);

  lseq_top #(.NUM_BANKS(NB), .ADDR_W(AW), .FETCH_LAT(LAT), .HALF_DEPTH(HD), .MAX_LAYERS(ML)) i_lseq_top (
    .clk_i(clk), .rst_ni, .start_i, .last_layer_i, .busy_o, .done_o, .err_o, .layer_o,
    .desc_base_i, .desc_in_len_i, .desc_out_cnt_i, .bank_addr_o, .bank_rd_en_o,
    .wgt_vld_o, .mac_en_o, .quant_o, .buf_rd_en_o, .buf_rd_src_o, .buf_rd_addr_o,
    .buf_wr_en_o, .buf_wr_half_o, .buf_wr_addr_o
  );

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic set_layer(input int l, input int base, input int len, input int cnt);
    d_base[l] = base; d_len[l] = len; d_cnt[l] = cnt;
  endtask

  // runs a chain; bad >= 0 marks the layer expected to be rejected
  task automatic run(input int nl, input int bad, input bit poke);
    int since;
    int wrs;
    int dones;
    bit poked;
    since = 0; wrs = 0; dones = 0; poked = 0;
    last_layer_i = YW'(nl - 1);
    start_i = 1'b1; tick(); start_i = 1'b0;
    chk_eq("R1 busy after start", int'(busy_o), 1);
    chk_eq("R9 err cleared by start", int'(err_o), 0);
    for (int L = 0; L < nl; L++) begin
      int dst;
      int src;
      if (L == bad) begin
        for (int k = 0; k < 4; k++) begin
          if (buf_wr_en_o) wrs++;
          if (done_o) dones++;
          tick();
        end
        chk_eq("R9 err raised", int'(err_o), 1);
        chk_eq("R9 idle after reject", int'(busy_o), 0);
        chk_eq("R9 no write after reject", wrs, 0);
        chk_eq("R9 no done after reject", dones, 0);
        return;
      end
      dst = L % 2;
      src = (L == 0) ? 0 : ((L % 2 == 1) ? 1 : 2);
      for (int o = 0; o < d_cnt[L]; o++) begin
        int addr;
        int n;
        bit exp_hit;
        addr = (d_base[L] + o) % 256;
        n = 0;
        while (!(bank_rd_en_o != '0 || wgt_vld_o) && n < 200) begin
          tick(); since++; n++;
        end
        exp_hit = m_vld && (m_last == addr);
        if (bank_rd_en_o != '0) begin
          chk_eq("R4/R5 read issued only on new address", int'(exp_hit), 0);
          chk_eq("R2 all banks enabled", int'(bank_rd_en_o), 255);
          for (int b = 0; b < NB; b++)
            chk_eq("R2 bank address", int'(bank_addr_o[b*AW +: AW]), addr);
          m_vld = 1; m_last = addr;
          n = 0;
          while (!wgt_vld_o && n < 200) begin
            if (mac_en_o) chk_eq("R3 no compute before weights", 1, 0);
            if (poke && !poked) begin start_i = 1'b1; poked = 1; end
            tick(); start_i = 1'b0; n++;
          end
          chk_eq("R3 fetch latency", n, LAT);
        end else begin
          chk_eq("R4 repeat address skips read", int'(exp_hit), 1);
          chk(since <= 3, "R4 prompt start on repeat", since, 3);
        end
        for (int i = 0; i < d_len[L]; i++) begin
          chk_eq("R6 compute cycle", int'(mac_en_o && buf_rd_en_o), 1);
          chk_eq("R6 read address", int'(buf_rd_addr_o), i);
          if (L == 0) chk_eq("R7 read source", int'(buf_rd_src_o), src);
          else        chk_eq("R8 read source", int'(buf_rd_src_o), src);
          tick();
        end
        chk_eq("R6 quant cycle", int'(quant_o && !buf_rd_en_o && !mac_en_o), 1);
        tick();
        chk_eq("R6 write cycle", int'(buf_wr_en_o && !buf_rd_en_o), 1);
        chk_eq("R6 write address", int'(buf_wr_addr_o), o);
        if (L == 0) chk_eq("R7 write half", int'(buf_wr_half_o), dst);
        else        chk_eq("R8 write half", int'(buf_wr_half_o), dst);
        tick();
        since = 1;
      end
    end
    chk_eq("R10 done after last write", int'(done_o), 1);
    tick();
    chk_eq("R10 done single cycle", int'(done_o), 0);
    chk_eq("R1 idle after chain", int'(busy_o), 0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    m_vld = 0;
    repeat (3) tick();
    chk_eq("R11 reset idle", int'(busy_o || done_o || err_o), 0);
    chk_eq("R11 reset enables", int'(bank_rd_en_o != '0 || buf_rd_en_o || buf_wr_en_o), 0);
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic t_single_from_zero();
    set_layer(0, 0, 3, 2);  // address 0 right after reset must still be read (R5)
    run(1, -1, 0);
  endtask

  task automatic t_three_layers_with_poke();
    set_layer(0, 10, 2, 3);
    set_layer(1, 12, 8, 2);  // starts on row 12, repeat of previous row (R4)
    set_layer(2, 40, 1, 1);
    run(3, -1, 1);           // extra start while busy (R1)
  endtask

  task automatic t_rerun_repeat();
    set_layer(0, 40, 2, 1);
    run(1, -1, 0);
  endtask

  task automatic t_rejects();
    set_layer(0, 70, 0, 1);
    run(1, 0, 0);
    set_layer(0, 70, HD + 1, 1);
    run(1, 0, 0);
    set_layer(0, 70, 1, HD + 1);
    run(1, 0, 0);
    set_layer(0, 50, 1, 1);
    set_layer(1, 51, HD + 1, 1);
    run(2, 1, 0);
  endtask

  task automatic t_full_boundary();
    set_layer(0, 60, HD, HD);
    run(1, -1, 0);
  endtask

  initial begin
    for (int l = 0; l < ML; l++) set_layer(l, 0, 1, 1);
    t_reset();
    t_single_from_zero();
    t_three_layers_with_poke();
    t_rerun_repeat();
    t_rejects();
    t_full_boundary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule